// File: doc/BRIEF.md
# Cascade ID Buffer and Comparator

This block lets several interrupt controllers share one interrupt line to the processor. It does this over a 3-bit cascade bus whose direction follows the controller's role. When the controller is the master, it latches the granted level at the first acknowledge pulse. If that level has a subordinate controller attached, the master drives the level number onto the cascade bus for the whole acknowledge sequence. If no subordinate is attached, the master keeps the bus at zero and enables its own vector. When the controller is a subordinate, it compares the cascade bus with its programmed ID at the end of the first acknowledge pulse. A match enables the subordinate's vector output for the rest of the sequence.

An acknowledge sequence is two or three pulses long, set by a mode input at the first pulse. A request that has disappeared before the acknowledge arrives is handled as level 7 (all ones). The bidirectional bus appears at the ports as a separate input, output and output enable. The chip's pad logic joins them.

Top module: `casc_id_unit`

## Requirements
- R1: After reset, `cas_oe`, `cas_out` and `vec_en` are all 0.
- R2: In master role, when the level latched at the first rising edge of `ack` has its `slave_map` bit set, `cas_out` equals that level and `cas_oe` is 1. Both take effect from the clock edge that sees the first rising edge of `ack` and last until the clock edge that sees the last falling edge.
- R3: In master role, when the latched level has its `slave_map` bit clear, `cas_oe` is 1 and `cas_out` is 0 for the sequence. `vec_en` becomes 1 at the clock edge that sees the first pulse fall.
- R4: In master role, when the latched level has a subordinate attached, `vec_en` stays 0 for the whole sequence.
- R5: If `grant_valid` is 0 at the first rising edge of `ack`, the sequence uses level 7 in every respect.
- R6: In subordinate role (`is_master`=0 at the first pulse), `cas_oe` and `cas_out` stay 0.
- R7: In subordinate role, if `cas_in` equals `own_id` at the clock edge that sees the first pulse fall, `vec_en` becomes 1 at that edge. It stays 1 until the end of the sequence.
- R8: In subordinate role, if `cas_in` differs from `own_id` at that edge, `vec_en` stays 0.
- R9: Once latched, the match result is unaffected by later changes of `cas_in` within the sequence.
- R10: A sequence ends at the falling edge of its third pulse if `three_pulse` was 1 at its first rising edge, and of its second pulse otherwise. At that edge, `cas_oe`, `cas_out` and `vec_en` return to 0.
- R11: Changes to `is_master`, `slave_map`, `grant_valid`, `grant_level` and `three_pulse` after the first rising edge have no effect until the next sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| is_master | input | 1 | 1 selects master role, 0 subordinate role |
| own_id | input | 3 | Programmed ID of this controller in subordinate role |
| slave_map | input | 8 | Bit n set: input level n has a subordinate controller |
| grant_valid | input | 1 | A granted request is present |
| grant_level | input | 3 | Granted interrupt level |
| three_pulse | input | 1 | 1: three-pulse acknowledge sequence, 0: two-pulse |
| ack | input | 1 | Acknowledge strobe, synchronous to clk |
| cas_in | input | 3 | Cascade bus as seen at the pins |
| cas_out | output | 3 | Cascade bus value driven in master role |
| cas_oe | output | 1 | Cascade bus output enable |
| vec_en | output | 1 | This controller drives its vector on the data bus |

## Verification
The hardest case to reach is a sequence in which every control input changes partway through. In that case the role, the grant, the pulse count and the cascade value seen by a subordinate must all stay frozen at their first-pulse values. The stimulus therefore inverts every one of these inputs right after the first pulse of every sequence. The only exception is `own_id`, which holds the controller's programmed configuration for its subordinate role. The stimulus then checks all outputs after each later pulse. It sweeps several slave maps, every level, both grant states and both pulse counts in master role. In subordinate role it sweeps every pairing of ID and cascade value.

// File: rtl/casc_pkg.sv
package casc_pkg;

   localparam int CASC_CNT_W = 2;

   typedef struct packed {
      logic start;      // first rising ack edge of a sequence
      logic first_end;  // falling edge of the first pulse
      logic last_end;   // falling edge of the final pulse
      logic active;     // a sequence is in progress
   } casc_evt_t;

   function automatic logic [CASC_CNT_W-1:0] pulses_needed(input logic three);
      return three ? CASC_CNT_W'(3) : CASC_CNT_W'(2);
   endfunction

endpackage

// File: rtl/casc_ack_track.sv
module casc_ack_track
   import casc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      ack,
   input  logic      three_pulse,
   output casc_evt_t evt
);

   logic                  ack_q;
   logic                  active_q;
   logic                  three_q;
   logic [CASC_CNT_W-1:0] cnt_q;
   logic                  rise, fall;

   assign rise = ack & ~ack_q;
   assign fall = ~ack & ack_q;

   always_comb begin
      evt.start     = rise & ~active_q;
      evt.first_end = fall & active_q & (cnt_q == CASC_CNT_W'(1));
      evt.last_end  = fall & active_q & (cnt_q == pulses_needed(three_q));
      evt.active    = active_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q    <= 1'b0;
         active_q <= 1'b0;
         three_q  <= 1'b0;
         cnt_q    <= '0;
      end else begin
         ack_q <= ack;
         if (evt.start) begin
            active_q <= 1'b1;
            cnt_q    <= CASC_CNT_W'(1);
            three_q  <= three_pulse;
         end else if (evt.last_end) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
         end else if (rise && active_q) begin
            cnt_q <= cnt_q + CASC_CNT_W'(1);
         end
      end
   end

   assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |-> (cnt_q >= CASC_CNT_W'(1) && cnt_q <= CASC_CNT_W'(3)));

   assert_end_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active_q) |-> ($past(ack_q) && !$past(ack)));

endmodule

// File: rtl/casc_master_drv.sv
module casc_master_drv #(
   parameter int ID_W = 3,
   parameter int NLVL = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            last_end,
   input  logic            is_master,
   input  logic [NLVL-1:0] slave_map,
   input  logic            grant_valid,
   input  logic [ID_W-1:0] grant_level,
   output logic            role_q,
   output logic            drv_oe,
   output logic [ID_W-1:0] drv_id,
   output logic            self_vec
);

   localparam logic [ID_W-1:0] DEFAULT_LVL = {ID_W{1'b1}};

   logic [ID_W-1:0] eff_lvl;
   logic            has_sub;

   assign eff_lvl = grant_valid ? grant_level : DEFAULT_LVL;
   assign has_sub = slave_map[eff_lvl];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         role_q   <= 1'b0;
         drv_oe   <= 1'b0;
         drv_id   <= '0;
         self_vec <= 1'b0;
      end else if (start) begin
         role_q   <= is_master;
         drv_oe   <= is_master;
         drv_id   <= (is_master && has_sub) ? eff_lvl : '0;
         self_vec <= is_master & ~has_sub;
      end else if (last_end) begin
         role_q   <= 1'b0;
         drv_oe   <= 1'b0;
         drv_id   <= '0;
         self_vec <= 1'b0;
      end
   end

   assert_id_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !drv_oe |-> (drv_id == '0));

   assert_self_only_master_R3: assert property (@(posedge clk) disable iff (!rst_n)
      self_vec |-> (role_q && drv_oe));

endmodule

// File: rtl/casc_slave_cmp.sv
module casc_slave_cmp #(
   parameter int ID_W = 3
) (
   input  logic [ID_W-1:0] own_id,
   input  logic [ID_W-1:0] cas_in,
   output logic            hit
);

   logic [ID_W-1:0] bit_eq;

   for (genvar b = 0; b < ID_W; b++) begin : g_bit
      assign bit_eq[b] = ~(own_id[b] ^ cas_in[b]);
   end

   assign hit = &bit_eq;

endmodule

// File: rtl/casc_id_unit.sv
module casc_id_unit
   import casc_pkg::*;
#(
   parameter int ID_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 is_master,
   input  logic [ID_W-1:0]      own_id,
   input  logic [(1<<ID_W)-1:0] slave_map,
   input  logic                 grant_valid,
   input  logic [ID_W-1:0]      grant_level,
   input  logic                 three_pulse,
   input  logic                 ack,
   input  logic [ID_W-1:0]      cas_in,
   output logic [ID_W-1:0]      cas_out,
   output logic                 cas_oe,
   output logic                 vec_en
);

   localparam int NLVL = 1 << ID_W;

   if (ID_W != 3) begin : g_bad_width
      $error("casc_id_unit: cascade bus must be 3 bits wide");
   end

   casc_evt_t evt;
   logic      role_q, self_vec, hit;

   casc_ack_track u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .ack         (ack),
      .three_pulse (three_pulse),
      .evt         (evt)
   );

   casc_master_drv #(.ID_W(ID_W), .NLVL(NLVL)) u_master (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (evt.start),
      .last_end    (evt.last_end),
      .is_master   (is_master),
      .slave_map   (slave_map),
      .grant_valid (grant_valid),
      .grant_level (grant_level),
      .role_q      (role_q),
      .drv_oe      (cas_oe),
      .drv_id      (cas_out),
      .self_vec    (self_vec)
   );

   casc_slave_cmp #(.ID_W(ID_W)) u_cmp (
      .own_id (own_id),
      .cas_in (cas_in),
      .hit    (hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_en <= 1'b0;
      end else if (evt.first_end) begin
         vec_en <= role_q ? self_vec : hit;
      end else if (evt.last_end) begin
         vec_en <= 1'b0;
      end
   end

   assert_vec_in_seq_R7: assert property (@(posedge clk) disable iff (!rst_n)
      vec_en |-> evt.active);

   assert_slave_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !role_q |-> !cas_oe);

   assert_oe_on_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cas_oe) |-> $past(ack));

   assert_vec_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_en && !evt.last_end) |=> vec_en);

   assert_master_defers_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (role_q && cas_out != '0) |-> !vec_en);

endmodule

// File: tb/tb_casc_id_unit.sv
module tb_casc_id_unit;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       is_master = 1'b0;
   logic [2:0] own_id = '0;
   logic [7:0] slave_map = '0;
   logic       grant_valid = 1'b0;
   logic [2:0] grant_level = '0;
   logic       three_pulse = 1'b0;
   logic       ack = 1'b0;
   logic [2:0] cas_in = '0;
   logic [2:0] cas_out;
   logic       cas_oe;
   logic       vec_en;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   casc_id_unit dut (
      .clk(clk), .rst_n(rst_n), .is_master(is_master), .own_id(own_id),
      .slave_map(slave_map), .grant_valid(grant_valid), .grant_level(grant_level),
      .three_pulse(three_pulse), .ack(ack), .cas_in(cas_in),
      .cas_out(cas_out), .cas_oe(cas_oe), .vec_en(vec_en)
   );

   task automatic chk(input string rq, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   task automatic chk_all(input string rq, input int oe, input int out, input int ve);
      chk(rq, "cas_oe", int'(cas_oe), oe);
      chk(rq, "cas_out", int'(cas_out), out);
      chk(rq, "vec_en", int'(vec_en), ve);
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   // One full acknowledge sequence; all inputs inverted after the first pulse.
   task automatic run_seq(input bit m, input logic [7:0] map, input bit gv,
                          input logic [2:0] lvl, input bit three,
                          input logic [2:0] id, input logic [2:0] cin);
      logic [2:0] el;
      bit         has;
      int         e_oe, e_out, e_vec, npulse;
      string      rq_out, rq_vec;
      el     = gv ? lvl : 3'd7;
      has    = map[el];
      e_oe   = m ? 1 : 0;
      e_out  = (m && has) ? int'(el) : 0;
      e_vec  = m ? int'(!has) : int'(cin == id);
      npulse = three ? 3 : 2;
      rq_out = m ? (gv ? "R2" : "R5") : "R6";
      rq_vec = m ? (has ? "R4" : "R3") : ((cin == id) ? "R7" : "R8");
      is_master = m; slave_map = map; grant_valid = gv; grant_level = lvl;
      three_pulse = three; own_id = id; cas_in = cin;
      ack = 1'b1; tick;
      chk_all(rq_out, e_oe, e_out, 0);
      ack = 1'b0; tick;
      chk(rq_vec, "vec_en after first pulse", int'(vec_en), e_vec);
      chk(rq_out, "cas_out after first pulse", int'(cas_out), e_out);
      // R11 / R9: perturb every latched input
      is_master = ~m; slave_map = ~map; grant_valid = ~gv; grant_level = ~lvl;
      three_pulse = ~three; cas_in = ~cin;
      for (int p = 2; p <= npulse; p++) begin
         ack = 1'b1; tick;
         chk_all(m ? "R11" : "R9", e_oe, e_out, e_vec);
         ack = 1'b0; tick;
         if (p == npulse) chk_all("R10", 0, 0, 0);
         else chk_all("R11", e_oe, e_out, e_vec);
      end
      tick;
      chk_all("R10", 0, 0, 0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !finished) begin
         finished = 1'b1;
         total++; bad++;
         $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] maps [4];
      maps[0] = 8'h00; maps[1] = 8'hFF; maps[2] = 8'hA5; maps[3] = 8'h5A;
      repeat (3) @(negedge clk);
      chk_all("R1", 0, 0, 0);
      rst_n = 1'b1;
      tick;
      chk_all("R1", 0, 0, 0);
      for (int mi = 0; mi < 4; mi++)
         for (int l = 0; l < 8; l++)
            for (int g = 0; g < 2; g++)
               for (int t = 0; t < 2; t++)
                  run_seq(1'b1, maps[mi], g[0], 3'(l), t[0], 3'd0, 3'd0);
      for (int id = 0; id < 8; id++)
         for (int c = 0; c < 8; c++)
            for (int t = 0; t < 2; t++)
               run_seq(1'b0, 8'hFF, 1'b1, 3'd1, t[0], 3'(id), 3'(c));
      // R1: reset in the middle of a sequence clears everything
      is_master = 1'b1; slave_map = 8'hFF; grant_valid = 1'b1; grant_level = 3'd4;
      ack = 1'b1; tick;
      chk_all("R2", 1, 4, 0);
      rst_n = 1'b0; ack = 1'b0; tick;
      chk_all("R1", 0, 0, 0);
      rst_n = 1'b1; tick;
      chk_all("R1", 0, 0, 0);
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule